// File: doc/BRIEF.md
# Bidirectional RAM Playback Address Sequencer

This block produces read addresses for a waveform memory that is played back as a continuous triangle sweep. Two segment registers are presented as inputs, each with a first address, a last address and a 16-bit step-rate value. A select input picks the active segment. Playback begins on an update pulse or on any change of the select input. The address then climbs one step at a time from the first address to the last address, falls back to the first address, and repeats until the next trigger.

Steps are paced in one of two ways. In core-clock pacing, each address is held for M clock cycles, where M is the active segment's rate field. In port pacing, the address advances once for every cycle in which an external port-tick pulse is high. Each new address comes with a one-cycle read strobe, and a direction flag shows whether the sweep is falling.

Top module: `ram_sweep_seq`

## Requirements
- R1: After reset, rd_addr is 0, rd_stb is 0 and dir_down is 0, and no strobe occurs until the first trigger.
- R2: An update pulse sampled high at a clock edge starts playback. From the following cycle, rd_addr is the first address of the segment chosen by seg_sel (0 selects seg0, 1 selects seg1), dir_down is 0 and rd_stb is 1 for one cycle.
- R3: A change of seg_sel from its value in the previous cycle is a trigger. It aborts any running sweep and restarts at the first address of the newly selected segment, with the same timing as R2.
- R4: Each step moves the address by exactly one. It rises from first to last and then falls back to first, repeating indefinitely. Each terminal address is presented once per turn: first, first+1 .. last, last-1 .. first, first+1 ..
- R5: dir_down becomes 1 when the last address is presented and stays 1 until the first address is presented again, where it becomes 0.
- R6: With pace_port = 0, every address, including the one loaded by a trigger, is held for exactly M cycles. M is the active segment's rate field, and a rate of 0 is treated as 1.
- R7: With pace_port = 1, the address advances one cycle after each cycle in which port_tick is high, and the rate field has no effect.
- R8: rd_stb is high for exactly one cycle each time a new address is presented, and low in all other cycles.
- R9: When the first address equals the last address, the address stays constant after the trigger, and there is no strobe after the trigger strobe.
- R10: An update pulse during a running sweep restarts it at the first address of the currently selected segment, with dir_down 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg0_first | input | 10 | Segment 0 first (lower) address |
| seg0_last | input | 10 | Segment 0 last (upper) address |
| seg0_rate | input | 16 | Segment 0 step period in cycles |
| seg1_first | input | 10 | Segment 1 first address |
| seg1_last | input | 10 | Segment 1 last address |
| seg1_rate | input | 16 | Segment 1 step period in cycles |
| seg_sel | input | 1 | Active segment select; any change is a trigger |
| update | input | 1 | Playback (re)start pulse |
| pace_port | input | 1 | 1: pace by port_tick, 0: pace by rate timer |
| port_tick | input | 1 | One-cycle pacing pulse used when pace_port is 1 |
| rd_addr | output | 10 | Memory read address |
| rd_stb | output | 1 | One-cycle pulse per new address |
| dir_down | output | 1 | 1 while the sweep is falling |

## Verification
A table of segments is swept with different span widths: a two-address span that turns on every step, a mid-sized span, and a span ending at the top of the address space. These are run with rates of 3, 1 and 0 in core pacing and with a tick every third cycle in port pacing. The cases separate an off-by-one at either turn, an unclamped zero rate, and a port mode that wrongly follows the rate field. Directed cases toggle the select mid-sweep in both directions, pulse update while the sweep is falling, and program a span of one address. These show whether abort and restart use the right segment, and whether a degenerate span stays still.

// File: rtl/ram_sweep_seq.sv
module ram_sweep_seq #(
  parameter int AW = 10,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] seg0_first,
  input  logic [AW-1:0] seg0_last,
  input  logic [RW-1:0] seg0_rate,
  input  logic [AW-1:0] seg1_first,
  input  logic [AW-1:0] seg1_last,
  input  logic [RW-1:0] seg1_rate,
  input  logic          seg_sel,
  input  logic          update,
  input  logic          pace_port,
  input  logic          port_tick,
  output logic [AW-1:0] rd_addr,
  output logic          rd_stb,
  output logic          dir_down
);

  logic          sel_q, act_sel, running;
  logic [RW-1:0] tmr;

  wire           trig      = update | (seg_sel ^ sel_q);
  wire [AW-1:0]  new_first = seg_sel ? seg1_first : seg0_first;
  wire [AW-1:0]  cur_first = act_sel ? seg1_first : seg0_first;
  wire [AW-1:0]  cur_last  = act_sel ? seg1_last  : seg0_last;
  wire [RW-1:0]  cur_rate  = act_sel ? seg1_rate  : seg0_rate;
  wire [RW-1:0]  m_last    = (cur_rate == '0) ? '0 : cur_rate - 1'b1;
  wire           tick      = pace_port ? port_tick : (tmr >= m_last);
  wire           step      = running & ~trig & tick;
  wire           moves     = cur_first != cur_last;
  wire [AW-1:0]  nxt       = dir_down ? rd_addr - 1'b1 : rd_addr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      act_sel  <= 1'b0;
      running  <= 1'b0;
      tmr      <= '0;
      rd_addr  <= '0;
      rd_stb   <= 1'b0;
      dir_down <= 1'b0;
    end else begin
      sel_q  <= seg_sel;
      rd_stb <= 1'b0;
      if (trig) begin
        running  <= 1'b1;
        act_sel  <= seg_sel;
        rd_addr  <= new_first;
        dir_down <= 1'b0;
        tmr      <= '0;
        rd_stb   <= 1'b1;
      end else if (step) begin
        tmr <= '0;
        if (moves) begin
          rd_addr <= nxt;
          rd_stb  <= 1'b1;
          if (!dir_down && nxt == cur_last)
            dir_down <= 1'b1;
          else if (dir_down && nxt == cur_first)
            dir_down <= 1'b0;
        end
      end else if (running && !pace_port) begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !rd_stb);

  a_r2_trigger_load: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (rd_stb && !dir_down && rd_addr == $past(new_first)));

  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !$past(trig)) |->
      (rd_addr == AW'($past(rd_addr) + 1'b1) || rd_addr == AW'($past(rd_addr) - 1'b1)));

  a_r8_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |-> $stable(rd_addr));

  a_r9_flat_span: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !trig && !moves) |=> !rd_stb);

endmodule

// File: tb/tb_ram_sweep_seq.sv
module tb_ram_sweep_seq;
  localparam int AW = 10;
  localparam int RW = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] seg0_first = '0, seg0_last = '0, seg1_first = '0, seg1_last = '0;
  logic [RW-1:0] seg0_rate = '0, seg1_rate = '0;
  logic          seg_sel = 1'b0, update = 1'b0, pace_port = 1'b0, port_tick = 1'b0;
  logic [AW-1:0] rd_addr;
  logic          rd_stb, dir_down;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  ram_sweep_seq #(.AW(AW), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n),
    .seg0_first(seg0_first), .seg0_last(seg0_last), .seg0_rate(seg0_rate),
    .seg1_first(seg1_first), .seg1_last(seg1_last), .seg1_rate(seg1_rate),
    .seg_sel(seg_sel), .update(update), .pace_port(pace_port), .port_tick(port_tick),
    .rd_addr(rd_addr), .rd_stb(rd_stb), .dir_down(dir_down));

  typedef struct packed {
    logic [AW-1:0] first;
    logic [AW-1:0] last;
    logic [RW-1:0] rate;
    logic          pace;
    logic [7:0]    period;
    logic [7:0]    steps;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{first: 10'd10,   last: 10'd14,   rate: 16'd3,   pace: 1'b0, period: 8'd3, steps: 8'd20},
    '{first: 10'd0,    last: 10'd1,    rate: 16'd1,   pace: 1'b0, period: 8'd1, steps: 8'd8},
    '{first: 10'd5,    last: 10'd9,    rate: 16'd0,   pace: 1'b0, period: 8'd1, steps: 8'd12},
    '{first: 10'd100,  last: 10'd103,  rate: 16'd500, pace: 1'b1, period: 8'd3, steps: 8'd10},
    '{first: 10'd1020, last: 10'd1023, rate: 16'd2,   pace: 1'b0, period: 8'd2, steps: 8'd10}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_start(input int first, input string tag);
    chk(rd_addr == AW'(first), {tag, " addr"}, int'(rd_addr), first);
    chk(rd_stb == 1'b1, {tag, " stb"}, int'(rd_stb), 1);
    chk(dir_down == 1'b0, {tag, " dir"}, int'(dir_down), 0);
  endtask

  task automatic pulse_update(input int first, input string tag);
    @(negedge clk) update = 1'b1;
    @(negedge clk) update = 1'b0;
    expect_start(first, tag);
  endtask

  task automatic sweep(input int first, input int last, input int period,
                       input int steps, input bit pace, input string tag);
    int a = first;
    bit d = 1'b0;
    int gap = 0;
    int cyc = 0;
    int seen = 0;
    while (seen < steps) begin
      cyc++;
      port_tick = pace && (cyc % 3 == 0);
      @(negedge clk);
      gap++;
      if (rd_stb) begin
        if (!d) begin a++; if (a == last) d = 1'b1; end
        else begin a--; if (a == first) d = 1'b0; end
        chk(gap == period, {tag, " R6/R7/R8 step period"}, gap, period);
        chk(rd_addr == AW'(a), {tag, " R4 address"}, int'(rd_addr), a);
        chk(dir_down == d, {tag, " R5 direction"}, int'(dir_down), int'(d));
        gap = 0;
        seen++;
      end else if (gap > period) begin
        chk(1'b0, {tag, " R8 missing strobe"}, gap, period);
        seen = steps;
      end
    end
    port_tick = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(rd_addr == '0, "R1 reset addr", int'(rd_addr), 0);
    chk(rd_stb == 1'b0, "R1 reset stb", int'(rd_stb), 0);
    chk(dir_down == 1'b0, "R1 reset dir", int'(dir_down), 0);
    seg0_first = 10'd20; seg0_last = 10'd25; seg0_rate = 16'd1;
    begin
      int stb_seen = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (rd_stb) stb_seen++;
      end
      chk(stb_seen == 0, "R1 idle before trigger", stb_seen, 0);
    end

    for (int v = 0; v < 5; v++) begin
      seg0_first = VEC[v].first;
      seg0_last  = VEC[v].last;
      seg0_rate  = VEC[v].rate;
      pace_port  = VEC[v].pace;
      pulse_update(int'(VEC[v].first), "R2 table start");
      sweep(int'(VEC[v].first), int'(VEC[v].last), int'(VEC[v].period),
            int'(VEC[v].steps), VEC[v].pace, "table");
    end

    pace_port = 1'b0;
    seg0_first = 10'd30; seg0_last = 10'd34; seg0_rate = 16'd2;
    seg1_first = 10'd200; seg1_last = 10'd202; seg1_rate = 16'd2;
    pulse_update(30, "R2 seg0 start");
    sweep(30, 34, 2, 3, 1'b0, "pre-abort");
    @(negedge clk) seg_sel = 1'b1;
    @(negedge clk);
    expect_start(200, "R3 toggle to seg1");
    sweep(200, 202, 2, 5, 1'b0, "R3 seg1 sweep");
    @(negedge clk) seg_sel = 1'b0;
    @(negedge clk);
    expect_start(30, "R3 toggle to seg0");
    sweep(30, 34, 2, 6, 1'b0, "R3 seg0 sweep");
    chk(dir_down == 1'b1, "R10 precondition falling", int'(dir_down), 1);
    pulse_update(30, "R10 update mid-sweep");
    sweep(30, 34, 2, 4, 1'b0, "R10 resweep");

    seg0_first = 10'd50; seg0_last = 10'd50; seg0_rate = 16'd1;
    pulse_update(50, "R9 flat start");
    begin
      int stb_seen = 0;
      int moved = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (rd_stb) stb_seen++;
        if (rd_addr != 10'd50) moved++;
      end
      chk(stb_seen == 0, "R9 no strobe on flat span", stb_seen, 0);
      chk(moved == 0, "R9 address constant", moved, 0);
    end

    seg0_first = 10'd60; seg0_last = 10'd63; seg0_rate = 16'd4;
    pace_port = 1'b1;
    pulse_update(60, "R7 port start");
    begin
      int stb_seen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (rd_stb) stb_seen++;
      end
      chk(stb_seen == 0, "R7 no advance without port_tick", stb_seen, 0);
      chk(rd_addr == 10'd60, "R7 addr held without tick", int'(rd_addr), 60);
    end
    pace_port = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule